// File: doc/BRIEF.md
# Indirect Coefficient RAM Access Port

This block puts a small coefficient memory behind two registers on a simple register bus: a control register and a data register. Software first writes the control register. This write picks the transfer direction and turns sequential stepping on or off. It can also load an internal word pointer. Software then moves coefficients one word at a time through the data register. After each accepted data access the port holds a busy flag for a fixed number of cycles. Software polls this flag in the top bit of the control register before it starts the next access.

A typical load sequence writes the control register with pointer 0, the load flag, write direction and stepping on. It then writes the coefficients to the data register one after another, waiting for busy to clear between writes. Read-back works the same way with read direction selected. Each read of the data register returns the word at the pointer and then steps the pointer. The register bus takes one request per cycle and has no back-pressure. A read gets its response, with a valid pulse, exactly one cycle after the request. A write gets no response.

Top module: `coef_ram_port`

## Requirements
- R1: After reset the control register reads 0x00004000: pointer 0, write direction, stepping off, busy clear. Every stored word reads 0.
- R2: A control register read (offset 0x104) returns busy in bit 31, direction in bit 14 (1 = write), stepping enable in bit 12 and the current pointer in bits 8:0. Every other bit reads 0, including bit 13.
- R3: An accepted control write always takes direction from bit 14 and stepping from bit 12. It loads the pointer from bits 8:0 only when bit 13 is set; otherwise the pointer keeps its value.
- R4: In write direction, a data register write (offset 0x108) that is not blocked by busy stores the word at the pointer. The pointer then steps by one if stepping is on.
- R5: The pointer is 9 bits wide and steps from 511 to 0.
- R6: In read direction, a data register read that is not blocked by busy returns the word at the pointer. The pointer then steps by one if stepping is on; with stepping off it stays.
- R7: Each accepted data access makes busy read 1 for exactly HOLD cycles (default 3), starting in the cycle after the access.
- R8: A data access made while busy is 1 has no effect. It stores nothing, does not move the pointer, does not lengthen busy, and a read returns 0.
- R9: A control write made while busy is 1 is ignored: direction, stepping and pointer stay unchanged.
- R10: A data access against the selected direction is ignored. A data write in read direction stores nothing. A data read in write direction returns 0, does not move the pointer and does not start busy.
- R11: When the pointer is at or above DEPTH (default 32 words), a data write stores nothing and a data read returns 0. The access still steps the pointer and still starts busy.
- R12: Every read request gets bus_rvalid exactly one cycle later. A read of any offset other than the two registers returns 0. Write requests get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register request this cycle |
| bus_we | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | ADDR_W (12) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after a read request |
| bus_rdata | output | 32 | Read response data |

## Verification
A wrong pointer shows up in the control register read-back as soon as software reads it. It also shows up as a wrong word on the next data read. A mistake in the busy count shows up in bit 31 within a few cycles. It also shows up as an access that is accepted when it should have been dropped, or dropped when it should have been accepted. The bench checks this by comparing against a reference model on every clock. A store into the wrong word stays hidden until that word is read back, so every loaded word is read back in read direction before the run ends.

// File: rtl/coef_port_pkg.sv
package coef_port_pkg;
  localparam int WORD_W   = 32;
  localparam int PTR_W    = 9;
  localparam int CTRL_OFS = 32'h104;
  localparam int DATA_OFS = 32'h108;
  localparam int B_SEQ    = 12;
  localparam int B_INIT   = 13;
  localparam int B_DIR    = 14;
  localparam int B_BUSY   = 31;

  typedef struct packed {
    logic dir_wr;
    logic seq;
  } mode_t;

  function automatic logic [WORD_W-1:0] ctrl_image(input logic busy, input mode_t m,
                                                   input logic [PTR_W-1:0] ptr);
    logic [WORD_W-1:0] v;
    v = '0;
    v[B_BUSY] = busy;
    v[B_DIR]  = m.dir_wr;
    v[B_SEQ]  = m.seq;
    v[PTR_W-1:0] = ptr;
    return v;
  endfunction
endpackage

// File: rtl/coef_busy_timer.sv
module coef_busy_timer #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start)            cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R7
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R8
  no_restart_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/coef_addr_ptr.sv
module coef_addr_ptr #(
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (load)  ptr_q <= load_val;
    else if (step)  ptr_q <= ptr_q + 1'b1;
  end

  assign ptr = ptr_q;

  // R4 R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr == $past(load_val));
endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int DEPTH  = 32,
  parameter int PTR_W  = 9,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int  IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit  FULL  = (DEPTH >= (1 << PTR_W));

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic              hit;
  logic [IDX_W-1:0]  idx;

  generate
    if (FULL) begin : g_full
      assign hit = 1'b1;
    end else begin : g_part
      assign hit = (int'(addr) < DEPTH);
    end
  endgenerate

  assign idx = IDX_W'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we && hit) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = hit ? mem_q[idx] : '0;
endmodule

// File: rtl/coef_ram_port.sv
module coef_ram_port
  import coef_port_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 32,
  parameter int HOLD   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata
);
  logic             hit_ctrl, hit_data, busy;
  logic             ctrl_wr, wr_go, rd_go, access_go;
  logic [PTR_W-1:0] ptr;
  logic [31:0]      store_rd;
  mode_t            mode_q;
  logic             rvalid_q;
  logic [31:0]      rdata_q;

  assign hit_ctrl  = bus_req && (bus_addr == ADDR_W'(CTRL_OFS));
  assign hit_data  = bus_req && (bus_addr == ADDR_W'(DATA_OFS));
  assign ctrl_wr   = hit_ctrl && bus_we && !busy;
  assign wr_go     = hit_data && bus_we && !busy && mode_q.dir_wr;
  assign rd_go     = hit_data && !bus_we && !busy && !mode_q.dir_wr;
  assign access_go = wr_go || rd_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{dir_wr: 1'b1, seq: 1'b0};
    end else if (ctrl_wr) begin
      mode_q.dir_wr <= bus_wdata[B_DIR];
      mode_q.seq    <= bus_wdata[B_SEQ];
    end
  end

  coef_busy_timer #(.HOLD(HOLD)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(access_go), .busy(busy)
  );

  coef_addr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(ctrl_wr && bus_wdata[B_INIT]), .load_val(bus_wdata[PTR_W-1:0]),
    .step(access_go && mode_q.seq), .ptr(ptr)
  );

  coef_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_go), .addr(ptr),
    .wdata(bus_wdata), .rdata(store_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_req && !bus_we;
      if (bus_req && !bus_we) begin
        if (hit_ctrl)   rdata_q <= ctrl_image(busy, mode_q, ptr);
        else if (rd_go) rdata_q <= store_rd;
        else            rdata_q <= '0;
      end
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

  // R9
  ctrl_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctrl && bus_we && busy) |=> ($stable(mode_q) && $stable(ptr)));

  // R12
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  // R12
  no_write_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);
endmodule

// File: tb/coef_ram_port_tb.sv
module coef_ram_port_tb;
  localparam int DEPTH = 32;
  localparam int HOLD  = 3;
  localparam logic [11:0] CTRL = 12'h104;
  localparam logic [11:0] DATA = 12'h108;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  coef_ram_port #(.ADDR_W(12), .DEPTH(DEPTH), .HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  // behavioural reference model
  int          m_ptr, m_busy;
  bit          m_dirw, m_seq;
  logic [31:0] m_mem [DEPTH];
  bit          e_rv;
  logic [31:0] e_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_busy = 0; m_dirw = 1; m_seq = 0; e_rv = 0; e_rd = '0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    end else begin
      bit bsy, hc, hd, gw, gr;
      bsy = (m_busy > 0);
      hc  = bus_req && bus_addr == CTRL;
      hd  = bus_req && bus_addr == DATA;
      e_rv = bus_req && !bus_we;
      e_rd = '0;
      if (e_rv && hc) begin
        e_rd[31] = bsy; e_rd[14] = m_dirw; e_rd[12] = m_seq; e_rd[8:0] = m_ptr[8:0];
      end
      gw = hd && bus_we && !bsy && m_dirw;
      gr = hd && !bus_we && !bsy && !m_dirw;
      if (gr && m_ptr < DEPTH) e_rd = m_mem[m_ptr];
      if (gw && m_ptr < DEPTH) m_mem[m_ptr] = bus_wdata;
      if (m_busy > 0) m_busy--;
      if (gw || gr) begin
        m_busy = HOLD;
        if (m_seq) m_ptr = (m_ptr + 1) % 512;
      end
      if (hc && bus_we && !bsy) begin
        m_dirw = bus_wdata[14];
        m_seq  = bus_wdata[12];
        if (bus_wdata[13]) m_ptr = int'(bus_wdata[8:0]);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (bus_rvalid !== e_rv) begin
        errors++;
        $display("FAIL %s rvalid actual %0b expected %0b", cur_req, bus_rvalid, e_rv);
      end
      if (e_rv) begin
        checks++;
        if (bus_rdata !== e_rd) begin
          errors++;
          $display("FAIL %s rdata actual %08h expected %08h", cur_req, bus_rdata, e_rd);
        end
      end
    end
  end

  task automatic op(input bit we, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
    end
  endtask

  function automatic logic [31:0] coef(input int i);
    return 32'(i) * 32'h0123_4567 ^ 32'hA500_00F1;
  endfunction

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; op(0, CTRL, 0); idle(2);
    cur_req = "R12"; op(0, 12'h000, 0); op(0, 12'h10C, 0); op(1, 12'h200, 32'hFFFF); idle(2);
    // R4 R7 R2: load nine words, reading busy right after each write
    cur_req = "R4";
    op(1, CTRL, 32'h0000_7000);
    for (int i = 0; i < 9; i++) begin
      op(1, DATA, coef(i));
      cur_req = "R7"; op(0, CTRL, 0); op(0, CTRL, 0); op(0, CTRL, 0); op(0, CTRL, 0);
      cur_req = "R4";
    end
    cur_req = "R2"; op(0, CTRL, 0); idle(1);
    // R6 sequential read-back
    cur_req = "R6";
    op(1, CTRL, 32'h0000_3000);
    for (int i = 0; i < 9; i++) begin op(0, DATA, 0); idle(HOLD); end
    // R6 non-stepping reads
    op(1, CTRL, 32'h0000_2005);
    op(0, DATA, 0); idle(HOLD); op(0, DATA, 0); idle(HOLD); op(0, CTRL, 0); idle(1);
    // R3 control write without load flag
    cur_req = "R3"; op(1, CTRL, 32'h0000_5123); op(0, CTRL, 0); idle(1);
    // R8 second write during busy is dropped
    cur_req = "R8";
    op(1, DATA, 32'hDEAD_0001); op(1, DATA, 32'hDEAD_0002); op(0, DATA, 0);
    idle(HOLD); op(0, CTRL, 0);
    // R9 control write during busy
    cur_req = "R9";
    op(1, DATA, 32'hBEEF_0003); op(1, CTRL, 32'h0000_2000); op(0, CTRL, 0); idle(HOLD);
    op(0, CTRL, 0);
    // R10 wrong direction
    cur_req = "R10";
    op(0, DATA, 0); op(0, CTRL, 0);
    op(1, CTRL, 32'h0000_3005); op(1, DATA, 32'h1111_2222); op(0, CTRL, 0);
    op(0, DATA, 0); idle(HOLD);
    // R5 R11 wrap at 511 with out-of-range store
    cur_req = "R5";
    op(1, CTRL, 32'h0000_71FF); op(1, DATA, 32'h7777_7777); idle(HOLD); op(0, CTRL, 0);
    cur_req = "R11";
    op(1, CTRL, 32'h0000_3064); op(0, DATA, 0); idle(HOLD); op(0, CTRL, 0);
    // final read-back of the whole store
    cur_req = "R4";
    op(1, CTRL, 32'h0000_3000);
    for (int i = 0; i < DEPTH; i++) begin op(0, DATA, 0); idle(HOLD); end
    idle(3);
    finish_run();
  end
endmodule